// File: doc/BRIEF.md
# Split-Programmed Transfer Frame Counter

This block counts the frames of one SPI master transfer against a 32-bit target and tells the rest of the controller when that target has been met. The target is loaded through two write paths that follow different rules. A write to the control register replaces the lower half of the target with bits 23:8 of the written word and also zeroes the running count. A write to the upper-count register replaces only the upper half and leaves the lower half and the running count unchanged. The whole target can be read back as one 32-bit value.

A small state machine tracks the transfer and has three named states. ST_IDLE means the target is zero. ST_RUN means the target is non-zero and has not been reached. ST_DONE means it has been reached. Its transitions are:
- arm: ST_IDLE to ST_RUN, when the target becomes non-zero.
- disarm: ST_RUN to ST_IDLE, when the target becomes zero.
- finish: ST_RUN to ST_DONE, on the frame that brings the count up to the target.
- restart: any state to ST_IDLE or ST_RUN, on a count clear. The state chosen depends on the new target.

While the select-hold bit is set and the machine is in ST_RUN, the hold output keeps chip select asserted. This stays true even if the transmit FIFO upstream runs dry between frames.

Top module: `frame_tally`

## Requirements
- R1: After reset the target, the running count, `xfer_done` and `hold_sel` are all zero.
- R2: A control write sets target bits 15:0 to `ctrl_wdata[23:8]`, keeps target bits 31:16, and sets the running count to zero on the next edge.
- R3: An upper-count write sets target bits 31:16 to `upper_wdata[31:16]`. Bits 15:0 of that write are ignored, and the running count is left unchanged.
- R4: `target_rd` always presents the full 32-bit target, combining both halves.
- R5: Each `frame_done` pulse that arrives while the transfer is not complete raises `frame_cnt` by one.
- R6: `xfer_done` goes high one edge after the `frame_done` pulse that makes the running count equal the non-zero target.
- R7: Once `xfer_done` is high, it stays high and `frame_cnt` holds, whatever further frames arrive, until the count is cleared.
- R8: A command write with `cmd_wdata[4]` set clears the running count and `xfer_done` but keeps the target. A command write with bit 4 clear changes nothing.
- R9: A count clear (a control write or the command bit) arriving in the same cycle as `frame_done` takes priority, and the count becomes zero.
- R10: With a target of zero, `xfer_done` never rises, however many frames arrive.
- R11: `hold_sel` is high exactly when the select-hold bit (`ctrl_wdata[26]` at the last control write) is set and the transfer is running: the target is non-zero and not yet reached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | 32 | Control write data; bits 23:8 are the low target, bit 26 is select-hold |
| upper_wr | input | 1 | Upper-count register write strobe |
| upper_wdata | input | 32 | Upper-count write data; only bits 31:16 are used |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_wdata | input | 8 | Command data; bit 4 clears the running count |
| frame_done | input | 1 | One-cycle pulse at the end of each frame |
| xfer_done | output | 1 | Transfer complete, sticky until the count is cleared |
| target_rd | output | 32 | Full 32-bit target readback |
| frame_cnt | output | 32 | Running frame count |
| hold_sel | output | 1 | Keep chip select asserted for the counted transfer |

## Verification
The counter is driven to completion twice: once against a small target set only by a control write, and once against a target whose lower half is rewritten in the same cycle as a frame. This separates the compare against the full target from a compare against one half. Upper-count writes carry all ones in their low half, so any leak into the lower target shows up in the readback. Clears are applied together with frames, and also through a command word that lacks the clear bit. Together these tell clear priority apart from the no-effect case. A zero target followed by a stream of frames confirms that completion cannot fire by wraparound.

// File: rtl/frame_tally_pkg.sv
package frame_tally_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } tally_state_e;

endpackage

// File: rtl/tally_target.sv
module tally_target #(
    parameter int CNT_W   = 32,
    parameter int REG_W   = 32,
    parameter int LOW_LSB = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_wr,
    input  logic [REG_W-1:0] ctrl_wdata,
    input  logic             upper_wr,
    input  logic [REG_W-1:0] upper_wdata,
    output logic [CNT_W-1:0] tgt_q,
    output logic [CNT_W-1:0] tgt_next
);
    localparam int HALF_W = CNT_W / 2;

    // Each half of the target has its own write path.
    for (genvar h = 0; h < 2; h++) begin : g_half
        logic              wr_en;
        logic [HALF_W-1:0] wr_val;
        logic [HALF_W-1:0] half_q;

        if (h == 0) begin : g_low
            assign wr_en  = ctrl_wr;
            assign wr_val = ctrl_wdata[LOW_LSB +: HALF_W];
        end else begin : g_high
            assign wr_en  = upper_wr;
            assign wr_val = upper_wdata[REG_W-1 -: HALF_W];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                half_q <= '0;
            end else if (wr_en) begin
                half_q <= wr_val;
            end
        end

        assign tgt_q[h*HALF_W +: HALF_W]    = half_q;
        assign tgt_next[h*HALF_W +: HALF_W] = wr_en ? wr_val : half_q;
    end

    // R3: the lower half of the upper-count register is ignored
    assert_upper_low_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (upper_wr && !ctrl_wr) |=> (tgt_q[HALF_W-1:0] == $past(tgt_q[HALF_W-1:0])));

    // R2: a control write leaves the upper half alone
    assert_ctrl_keeps_upper_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !upper_wr) |=> (tgt_q[CNT_W-1:HALF_W] == $past(tgt_q[CNT_W-1:HALF_W])));

endmodule

// File: rtl/tally_counter.sv
module tally_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // R9: a clear outranks a frame in the same cycle
    assert_clear_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0));

    // R5: one step per counted frame
    assert_step_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

endmodule

// File: rtl/tally_fsm.sv
module tally_fsm
    import frame_tally_pkg::*;
#(
    parameter int CNT_W    = 32,
    parameter int REG_W    = 32,
    parameter int HOLD_BIT = 26
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             ctrl_wr,
    input  logic [REG_W-1:0] ctrl_wdata,
    input  logic             frame_done,
    input  logic [CNT_W-1:0] cnt_q,
    input  logic [CNT_W-1:0] tgt_next,
    output logic             count_en,
    output logic             done,
    output logic             hold
);
    tally_state_e state_q, state_d;
    logic         hold_en_q;
    logic         tgt_zero;
    logic         hits;

    assign tgt_zero = (tgt_next == '0);
    assign hits     = frame_done && ((cnt_q + CNT_W'(1)) == tgt_next);

    always_comb begin
        state_d = state_q;
        if (clr) begin
            state_d = tgt_zero ? ST_IDLE : ST_RUN;    // restart
        end else begin
            unique case (state_q)
                ST_IDLE: if (!tgt_zero) state_d = ST_RUN;   // arm
                ST_RUN: begin
                    if (tgt_zero)  state_d = ST_IDLE;       // disarm
                    else if (hits) state_d = ST_DONE;       // finish
                end
                ST_DONE: state_d = ST_DONE;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            hold_en_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (ctrl_wr) hold_en_q <= ctrl_wdata[HOLD_BIT];
        end
    end

    always_comb begin
        count_en = frame_done && (state_q != ST_DONE);
        done     = (state_q == ST_DONE);
        hold     = hold_en_q && (state_q == ST_RUN);
    end

    // R7: completion is sticky until a clear
    assert_done_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !clr) |=> done);

    // R11: hold never overlaps completion
    assert_hold_not_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> !done);

    // R8: a clear always removes completion
    assert_clear_drops_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !done);

endmodule

// File: rtl/frame_tally.sv
module frame_tally
    import frame_tally_pkg::*;
#(
    parameter int CNT_W    = 32,
    parameter int REG_W    = 32,
    parameter int CMD_W    = 8,
    parameter int LOW_LSB  = 8,
    parameter int HOLD_BIT = 26,
    parameter int CLR_BIT  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_wr,
    input  logic [REG_W-1:0] ctrl_wdata,
    input  logic             upper_wr,
    input  logic [REG_W-1:0] upper_wdata,
    input  logic             cmd_wr,
    input  logic [CMD_W-1:0] cmd_wdata,
    input  logic             frame_done,
    output logic             xfer_done,
    output logic [CNT_W-1:0] target_rd,
    output logic [CNT_W-1:0] frame_cnt,
    output logic             hold_sel
);
    logic [CNT_W-1:0] tgt_q;
    logic [CNT_W-1:0] tgt_next;
    logic [CNT_W-1:0] cnt_q;
    logic             clr;
    logic             count_en;

    // Both a control write and the command bit reset the running count.
    assign clr = ctrl_wr || (cmd_wr && cmd_wdata[CLR_BIT]);

    tally_target #(.CNT_W(CNT_W), .REG_W(REG_W), .LOW_LSB(LOW_LSB)) i_target (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctrl_wr     (ctrl_wr),
        .ctrl_wdata  (ctrl_wdata),
        .upper_wr    (upper_wr),
        .upper_wdata (upper_wdata),
        .tgt_q       (tgt_q),
        .tgt_next    (tgt_next)
    );

    tally_counter #(.CNT_W(CNT_W)) i_counter (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .inc   (count_en),
        .cnt_q (cnt_q)
    );

    tally_fsm #(.CNT_W(CNT_W), .REG_W(REG_W), .HOLD_BIT(HOLD_BIT)) i_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clr),
        .ctrl_wr    (ctrl_wr),
        .ctrl_wdata (ctrl_wdata),
        .frame_done (frame_done),
        .cnt_q      (cnt_q),
        .tgt_next   (tgt_next),
        .count_en   (count_en),
        .done       (xfer_done),
        .hold       (hold_sel)
    );

    assign target_rd = tgt_q;
    assign frame_cnt = cnt_q;

    // R10: completion never rises against a zero target
    assert_no_done_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xfer_done) |-> (target_rd != '0));

    // R6: completion rises exactly when the count meets the target
    assert_done_at_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xfer_done) |-> (frame_cnt == target_rd));

    // R2: a control write zeroes the running count
    assert_ctrl_resets_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> (frame_cnt == '0));

endmodule

// File: tb/test_frame_tally.sv
module test_frame_tally;

    localparam int OP_CTRL   = 0;
    localparam int OP_UPPER  = 1;
    localparam int OP_CMD    = 2;
    localparam int OP_FRAME  = 3;
    localparam int OP_FRCMD  = 4;
    localparam int OP_FRCTRL = 5;
    localparam int VW = 3 + 32 + 32 + 32 + 1 + 1;
    localparam int NV = 25;

    // {op, data, exp_cnt, exp_tgt, exp_done, exp_hold}
    localparam logic [VW-1:0] TBL [NV] = '{
        {3'd0, 32'h0400_0300, 32'd0, 32'h0000_0003, 1'b0, 1'b1}, // R2 R11
        {3'd3, 32'h0,         32'd1, 32'h0000_0003, 1'b0, 1'b1}, // R5
        {3'd3, 32'h0,         32'd2, 32'h0000_0003, 1'b0, 1'b1}, // R5
        {3'd3, 32'h0,         32'd3, 32'h0000_0003, 1'b1, 1'b0}, // R6
        {3'd3, 32'h0,         32'd3, 32'h0000_0003, 1'b1, 1'b0}, // R7
        {3'd2, 32'h08,        32'd3, 32'h0000_0003, 1'b1, 1'b0}, // R8 no clear bit
        {3'd2, 32'h10,        32'd0, 32'h0000_0003, 1'b0, 1'b1}, // R8
        {3'd1, 32'h0002_FFFF, 32'd0, 32'h0002_0003, 1'b0, 1'b1}, // R3 R4
        {3'd3, 32'h0,         32'd1, 32'h0002_0003, 1'b0, 1'b1}, // R5
        {3'd4, 32'h10,        32'd0, 32'h0002_0003, 1'b0, 1'b1}, // R9 cmd
        {3'd3, 32'h0,         32'd1, 32'h0002_0003, 1'b0, 1'b1}, // R5
        {3'd5, 32'h0000_0500, 32'd0, 32'h0002_0005, 1'b0, 1'b0}, // R9 ctrl R11
        {3'd1, 32'h0000_FFFF, 32'd0, 32'h0000_0005, 1'b0, 1'b0}, // R3
        {3'd3, 32'h0,         32'd1, 32'h0000_0005, 1'b0, 1'b0}, // R5
        {3'd3, 32'h0,         32'd2, 32'h0000_0005, 1'b0, 1'b0},
        {3'd3, 32'h0,         32'd3, 32'h0000_0005, 1'b0, 1'b0},
        {3'd3, 32'h0,         32'd4, 32'h0000_0005, 1'b0, 1'b0},
        {3'd3, 32'h0,         32'd5, 32'h0000_0005, 1'b1, 1'b0}, // R6
        {3'd0, 32'h0400_0000, 32'd0, 32'h0000_0000, 1'b0, 1'b0}, // R10 R11
        {3'd3, 32'h0,         32'd1, 32'h0000_0000, 1'b0, 1'b0}, // R10
        {3'd3, 32'h0,         32'd2, 32'h0000_0000, 1'b0, 1'b0}, // R10
        {3'd3, 32'h0,         32'd3, 32'h0000_0000, 1'b0, 1'b0}, // R10
        {3'd0, 32'h0400_0100, 32'd0, 32'h0000_0001, 1'b0, 1'b1}, // R2
        {3'd3, 32'h0,         32'd1, 32'h0000_0001, 1'b1, 1'b0}, // R6
        {3'd3, 32'h0,         32'd1, 32'h0000_0001, 1'b1, 1'b0}  // R7
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctrl_wr = 1'b0;
    logic [31:0] ctrl_wdata = '0;
    logic        upper_wr = 1'b0;
    logic [31:0] upper_wdata = '0;
    logic        cmd_wr = 1'b0;
    logic [7:0]  cmd_wdata = '0;
    logic        frame_done = 1'b0;
    logic        xfer_done;
    logic [31:0] target_rd;
    logic [31:0] frame_cnt;
    logic        hold_sel;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    frame_tally i_frame_tally (
        .clk(clk), .rst_n(rst_n),
        .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
        .upper_wr(upper_wr), .upper_wdata(upper_wdata),
        .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
        .frame_done(frame_done),
        .xfer_done(xfer_done), .target_rd(target_rd),
        .frame_cnt(frame_cnt), .hold_sel(hold_sel)
    );

    task automatic check(input string req, input logic [31:0] ec, input logic [31:0] et,
                         input logic ed, input logic eh);
        checks++;
        if (frame_cnt !== ec || target_rd !== et || xfer_done !== ed || hold_sel !== eh) begin
            errors++;
            $display("FAIL %s: cnt=%0d tgt=%h done=%b hold=%b, expected cnt=%0d tgt=%h done=%b hold=%b",
                     req, frame_cnt, target_rd, xfer_done, hold_sel, ec, et, ed, eh);
        end
    endtask

    task automatic idle_inputs();
        ctrl_wr = 1'b0; upper_wr = 1'b0; cmd_wr = 1'b0; frame_done = 1'b0;
    endtask

    task automatic apply(input int op, input logic [31:0] d);
        ctrl_wr    = (op == OP_CTRL) || (op == OP_FRCTRL);
        upper_wr   = (op == OP_UPPER);
        cmd_wr     = (op == OP_CMD) || (op == OP_FRCMD);
        frame_done = (op == OP_FRAME) || (op == OP_FRCMD) || (op == OP_FRCTRL);
        ctrl_wdata = d;
        upper_wdata = d;
        cmd_wdata  = d[7:0];
        @(negedge clk);
        idle_inputs();
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset", 32'd0, 32'd0, 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: frames before any write do not complete anything
        apply(OP_FRAME, 32'h0);
        check("R1 R10 frame on zero target", 32'd1, 32'd0, 1'b0, 1'b0);
        apply(OP_CTRL, 32'h0);

        for (int i = 0; i < NV; i++) begin
            logic [VW-1:0] v;
            string tag;
            v = TBL[i];
            apply(int'(v[VW-1 -: 3]), v[VW-4 -: 32]);
            tag = $sformatf("vector %0d (R2-related table step)", i);
            check(tag, v[65:34], v[33:2], v[1], v[0]);
        end

        // R3: upper write in the done state keeps done and count
        apply(OP_CTRL, 32'h0400_0200);
        apply(OP_FRAME, 32'h0);
        apply(OP_FRAME, 32'h0);
        check("R6 two-frame target", 32'd2, 32'd2, 1'b1, 1'b0);
        apply(OP_UPPER, 32'h0001_1234);
        check("R3 upper write after done", 32'd2, 32'h0001_0002, 1'b1, 1'b0);

        // R1: reset mid transfer returns everything to zero
        apply(OP_CTRL, 32'h0400_0900);
        apply(OP_FRAME, 32'h0);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset mid run", 32'd0, 32'd0, 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule